// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the digital back end of a two-channel 12-bit sampling converter. Each channel takes a raw sample in offset-binary form together with overrange and underrange flags. On every rising edge of the sample clock it registers a formatted code and an overflow bit. A shared two-bit mode setting selects the code format and reports whether the clock duty-cycle stabilizer would be active. A swap input then routes the two registered channels onto two output buses.

Each channel has its own output-disable and shutdown controls. Together they put that channel in a run, nap or sleep state. Tri-state pins are modelled as one drive-enable per bus. A per-channel valid flag marks when captured data can be trusted: it is low after reset until the first capture, and low during the timed recovery after nap or sleep. When the swap input is tied to the sample clock, both channels appear in turn on one bus, and the idle bus can be switched off with its own output-disable.

Top module: `dual_adc_fmt`

## Requirements
- R1: With mode level 0 or 1, a sample with neither flag set is output unchanged (offset binary; mid-scale is MSB=1, rest 0). With level 2 or 3, the same code is output with only its MSB inverted (two's complement; mid-scale is all zeros).
- R2: If the overrange flag is set, the output is full-scale positive and the overflow bit is 1. Full-scale positive is all ones in offset binary, and MSB=0 with all other bits 1 in two's complement. The overrange flag takes priority when both flags are set.
- R3: If only the underrange flag is set, the output is full-scale negative and the overflow bit is 1. Full-scale negative is all zeros in offset binary, and MSB=1 with all other bits 0 in two's complement.
- R4: With neither flag set, the overflow bit is 0.
- R5: `stab_en_o` is 1 for mode levels 1 and 2 and 0 for levels 0 and 3. It is registered on the sample clock, as is the format choice.
- R6: With `swap_i` high, channel A data and overflow appear on bus A and channel B on bus B. With `swap_i` low the two buses are exchanged, and each overflow bit goes with its data. This path is combinational from the registered channel data.
- R7: When `swap_i` follows the sample clock, bus A shows channel A during the high phase and channel B during the low phase.
- R8: Bus A is driven (`bus_a_drv_o`=1) only if `oe_off_i[0]` and `shdn_i[0]` were both low at the last clock edge. Bus B obeys the same rule with index 1. Index 0 is channel A and index 1 is channel B. Output-disable alone does not lower valid.
- R9: Shutdown high with output-disable low is nap. In nap the channel's bus is not driven and valid is 0. After shutdown is released, valid stays 0 for NAP_CYC clock edges, counting the first edge that sees shutdown low, and rises on the next edge.
- R10: Shutdown high with output-disable high is sleep. It behaves like nap, but the recovery lasts SLEEP_CYC edges, with SLEEP_CYC greater than NAP_CYC.
- R11: The power state, drive and valid of one channel do not depend on the other channel's controls. A channel in nap or sleep does not stop the other from capturing.
- R12: During reset, valid, drive and `stab_en_o` are 0. After reset releases, the first clock edge captures a sample and sets valid.
- R13: While a channel is in nap or sleep, its registered data and overflow bit hold their last captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode level 0..3 (format and stabilizer) |
| swap_i | input | 1 | Bus routing: 1 = straight, 0 = exchanged |
| oe_off_i | input | 2 | Per-channel output disable, high = off (0=A, 1=B) |
| shdn_i | input | 2 | Per-channel shutdown, high = nap/sleep (0=A, 1=B) |
| smp_a_i | input | DATA_W | Channel A raw sample, offset binary |
| ovr_a_i | input | 1 | Channel A overrange |
| und_a_i | input | 1 | Channel A underrange |
| smp_b_i | input | DATA_W | Channel B raw sample, offset binary |
| ovr_b_i | input | 1 | Channel B overrange |
| und_b_i | input | 1 | Channel B underrange |
| bus_a_o | output | DATA_W | Bus A data |
| bus_a_of_o | output | 1 | Bus A overflow |
| bus_a_drv_o | output | 1 | Bus A drive enable |
| bus_b_o | output | DATA_W | Bus B data |
| bus_b_of_o | output | 1 | Bus B overflow |
| bus_b_drv_o | output | 1 | Bus B drive enable |
| valid_o | output | 2 | Per-channel data valid (0=A, 1=B) |
| stab_en_o | output | 1 | Duty-cycle stabilizer enable status |

## Verification
The bench builds the block with DATA_W=6, NAP_CYC=4 and SLEEP_CYC=12. The narrow width makes an exhaustive sweep practical: every sample code is tried under every mode level and every flag combination, which covers both saturation codes and the MSB inversion at every value. The short recovery counts let the bench check every edge of both the nap and sleep recovery windows, and confirm that the sleep window is the longer one.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_NAP   = 2'd1,
    PWR_SLEEP = 2'd2
  } pwr_e;

  typedef struct packed {
    logic twos;
    logic stab;
  } mode_cfg_t;

endpackage

// File: rtl/adc_mode_dec.sv
module adc_mode_dec
  import adc_fmt_pkg::*;
(
  input  logic [1:0] lvl_i,
  output mode_cfg_t  cfg_o
);
  // upper half of the levels selects two's complement; middle two enable stabilizer
  always_comb begin
    cfg_o.twos = lvl_i[1];
    cfg_o.stab = lvl_i[1] ^ lvl_i[0];
  end
endmodule

// File: rtl/adc_chan_fmt.sv
module adc_chan_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int NAP_CYC   = 100,
  parameter int SLEEP_CYC = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              twos_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              ovr_i,
  input  logic              und_i,
  input  logic              shdn_i,
  input  logic              oe_off_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              of_o,
  output logic              drv_o,
  output logic              valid_o
);
  localparam int MAX_CYC = (SLEEP_CYC > NAP_CYC) ? SLEEP_CYC : NAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] NAP_LD   = CNT_W'(NAP_CYC - 1);
  localparam logic [CNT_W-1:0] SLEEP_LD = CNT_W'(SLEEP_CYC - 1);

  logic [DATA_W-1:0] sat, fmt;
  logic [DATA_W-1:0] dat_q;
  logic              of_q, drv_q, valid_q;
  logic [CNT_W-1:0]  cnt_q;
  pwr_e              pwr_q;

  always_comb begin
    if (ovr_i)      sat = '1;
    else if (und_i) sat = '0;
    else            sat = smp_i;
    fmt             = sat;
    fmt[DATA_W-1]   = sat[DATA_W-1] ^ twos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= PWR_RUN;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      drv_q   <= 1'b0;
      dat_q   <= '0;
      of_q    <= 1'b0;
    end else begin
      drv_q <= !shdn_i && !oe_off_i;
      if (shdn_i) begin
        pwr_q   <= oe_off_i ? PWR_SLEEP : PWR_NAP;
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        dat_q <= fmt;
        of_q  <= ovr_i | und_i;
        if (pwr_q != PWR_RUN) begin
          pwr_q   <= PWR_RUN;
          cnt_q   <= (pwr_q == PWR_SLEEP) ? SLEEP_LD : NAP_LD;
          valid_q <= 1'b0;
        end else if (cnt_q != '0) begin
          cnt_q   <= cnt_q - CNT_W'(1);
          valid_q <= 1'b0;
        end else begin
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign dat_o   = dat_q;
  assign of_o    = of_q;
  assign drv_o   = drv_q;
  assign valid_o = valid_q;

  AST_OVR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_i && ovr_i) |=> (of_o && (dat_o[DATA_W-2:0] == '1) &&
                            (dat_o[DATA_W-1] == !$past(twos_i)))); // R2
  AST_UND_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_i && !ovr_i && und_i) |=> (of_o && (dat_o[DATA_W-2:0] == '0) &&
                                      (dat_o[DATA_W-1] == $past(twos_i)))); // R3
  AST_SHDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> (!drv_o && !valid_o)); // R9
  AST_EXIT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_i) |=> !valid_o); // R10
  AST_SHDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> ($stable(dat_o) && $stable(of_o))); // R13
endmodule

// File: rtl/adc_bus_swap.sv
module adc_bus_swap #(
  parameter int DATA_W = 12
) (
  input  logic              swap_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic              a_of_i,
  input  logic [DATA_W-1:0] b_dat_i,
  input  logic              b_of_i,
  output logic [DATA_W-1:0] x_dat_o,
  output logic              x_of_o,
  output logic [DATA_W-1:0] y_dat_o,
  output logic              y_of_o
);
  always_comb begin
    if (swap_i) begin
      x_dat_o = a_dat_i; x_of_o = a_of_i;
      y_dat_o = b_dat_i; y_of_o = b_of_i;
    end else begin
      x_dat_o = b_dat_i; x_of_o = b_of_i;
      y_dat_o = a_dat_i; y_of_o = a_of_i;
    end
  end
endmodule

// File: rtl/dual_adc_fmt.sv
module dual_adc_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int NAP_CYC   = 100,
  parameter int SLEEP_CYC = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              swap_i,
  input  logic [1:0]        oe_off_i,
  input  logic [1:0]        shdn_i,
  input  logic [DATA_W-1:0] smp_a_i,
  input  logic              ovr_a_i,
  input  logic              und_a_i,
  input  logic [DATA_W-1:0] smp_b_i,
  input  logic              ovr_b_i,
  input  logic              und_b_i,
  output logic [DATA_W-1:0] bus_a_o,
  output logic              bus_a_of_o,
  output logic              bus_a_drv_o,
  output logic [DATA_W-1:0] bus_b_o,
  output logic              bus_b_of_o,
  output logic              bus_b_drv_o,
  output logic [1:0]        valid_o,
  output logic              stab_en_o
);
  localparam int NCH = 2;

  mode_cfg_t         cfg;
  logic              stab_q;
  logic [DATA_W-1:0] smp  [NCH];
  logic [DATA_W-1:0] dat  [NCH];
  logic [NCH-1:0]    ovr, und, of, drv;

  assign smp[0] = smp_a_i;
  assign smp[1] = smp_b_i;
  assign ovr    = {ovr_b_i, ovr_a_i};
  assign und    = {und_b_i, und_a_i};

  adc_mode_dec i_mode_dec (
    .lvl_i (mode_i),
    .cfg_o (cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stab_q <= 1'b0;
    else         stab_q <= cfg.stab;
  end
  assign stab_en_o = stab_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    adc_chan_fmt #(
      .DATA_W    (DATA_W),
      .NAP_CYC   (NAP_CYC),
      .SLEEP_CYC (SLEEP_CYC)
    ) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .twos_i   (cfg.twos),
      .smp_i    (smp[g]),
      .ovr_i    (ovr[g]),
      .und_i    (und[g]),
      .shdn_i   (shdn_i[g]),
      .oe_off_i (oe_off_i[g]),
      .dat_o    (dat[g]),
      .of_o     (of[g]),
      .drv_o    (drv[g]),
      .valid_o  (valid_o[g])
    );
  end

  adc_bus_swap #(.DATA_W(DATA_W)) i_swap (
    .swap_i  (swap_i),
    .a_dat_i (dat[0]),
    .a_of_i  (of[0]),
    .b_dat_i (dat[1]),
    .b_of_i  (of[1]),
    .x_dat_o (bus_a_o),
    .x_of_o  (bus_a_of_o),
    .y_dat_o (bus_b_o),
    .y_of_o  (bus_b_of_o)
  );

  // each bus pin group belongs to its own channel's enable
  assign bus_a_drv_o = drv[0];
  assign bus_b_drv_o = drv[1];

  AST_BUS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_a_o == dat[0] && bus_a_of_o == of[0] && bus_b_o == dat[1] && bus_b_of_o == of[1]) ||
    (bus_a_o == dat[1] && bus_a_of_o == of[1] && bus_b_o == dat[0] && bus_b_of_o == of[0])); // R6
  AST_STAB_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> !stab_en_o); // R5
endmodule

// File: tb/test_dual_adc_fmt.sv
module test_dual_adc_fmt;
  localparam int W     = 6;
  localparam int NAP   = 4;
  localparam int SLEEP = 12;
  localparam time CLK_P = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd1;
  logic         swap_r = 1'b1, swap_clk = 1'b0;
  logic [1:0]   oe_off = '0, shdn = '0;
  logic [W-1:0] smp_a = '0, smp_b = '0;
  logic         ovr_a = 0, und_a = 0, ovr_b = 0, und_b = 0;
  logic [W-1:0] bus_a, bus_b;
  logic         of_a, of_b, drv_a, drv_b, stab;
  logic [1:0]   valid;
  logic         swap;
  int           checks = 0, fails = 0;

  assign swap = swap_clk ? clk : swap_r;

  always #(CLK_P/2) clk = ~clk;

  dual_adc_fmt #(.DATA_W(W), .NAP_CYC(NAP), .SLEEP_CYC(SLEEP)) i_dual_adc_fmt (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .swap_i(swap),
    .oe_off_i(oe_off), .shdn_i(shdn),
    .smp_a_i(smp_a), .ovr_a_i(ovr_a), .und_a_i(und_a),
    .smp_b_i(smp_b), .ovr_b_i(ovr_b), .und_b_i(und_b),
    .bus_a_o(bus_a), .bus_a_of_o(of_a), .bus_a_drv_o(drv_a),
    .bus_b_o(bus_b), .bus_b_of_o(of_b), .bus_b_drv_o(drv_b),
    .valid_o(valid), .stab_en_o(stab)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_dat(input logic [W-1:0] c, input logic o, input logic u,
                                           input logic tc);
    int v;
    v = o ? (1 << W) - 1 : (u ? 0 : int'(c));
    if (tc) v = (v + (1 << (W-1))) % (1 << W);  // MSB flip as modular offset
    return W'(v);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    // R12 reset state
    repeat (3) @(negedge clk);
    chk(valid == 2'b00, "R12 valid in reset", valid, 0);
    chk(!drv_a && !drv_b, "R12 drive in reset", {drv_a, drv_b}, 0);
    chk(!stab, "R12 stab in reset", stab, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 2'b11, "R12 valid after first edge", valid, 3);
    chk(drv_a && drv_b, "R8 drive after reset", {drv_a, drv_b}, 3);

    // R1..R5 exhaustive sweep
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < (1 << W); c++) begin
        for (int f = 0; f < 4; f++) begin
          mode = 2'(m);
          smp_a = W'(c); ovr_a = f[0]; und_a = f[1];
          smp_b = ~W'(c); ovr_b = f[1]; und_b = f[0];
          @(negedge clk);
          chk(bus_a == exp_dat(W'(c), f[0], f[1], m[1]),
              f == 0 ? "R1 data A" : (f[0] ? "R2 data A" : "R3 data A"),
              bus_a, exp_dat(W'(c), f[0], f[1], m[1]));
          chk(bus_b == exp_dat(~W'(c), f[1], f[0], m[1]),
              f == 0 ? "R1 data B" : (f[1] ? "R2 data B" : "R3 data B"),
              bus_b, exp_dat(~W'(c), f[1], f[0], m[1]));
          chk(of_a == (f != 0) && of_b == (f != 0), "R4 overflow", {of_a, of_b}, (f != 0) ? 3 : 0);
          chk(stab == (m == 1 || m == 2), "R5 stab", stab, (m == 1 || m == 2));
        end
      end
    end

    // R6 static swap
    mode = 2'd0; smp_a = W'(5); ovr_a = 0; und_a = 0;
    smp_b = W'(9); ovr_b = 0; und_b = 1;
    @(negedge clk);
    swap_r = 1'b0; #1;
    chk(bus_a == '0 && of_a, "R6 swapped bus A", bus_a, 0);
    chk(bus_b == W'(5) && !of_b, "R6 swapped bus B", bus_b, 5);
    und_b = 0;
    @(negedge clk);
    chk(bus_a == W'(9) && bus_b == W'(5), "R6 swapped data", bus_a, 9);

    // R7 swap tied to clock
    swap_clk = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #(CLK_P/4);
      chk(bus_a == W'(5), "R7 high phase A", bus_a, 5);
      @(negedge clk); #(CLK_P/4);
      chk(bus_a == W'(9), "R7 low phase B", bus_a, 9);
    end
    swap_clk = 1'b0; swap_r = 1'b1;
    @(negedge clk);

    // R8 output disable only
    oe_off = 2'b01;
    @(negedge clk);
    chk(!drv_a && drv_b, "R8 disable A", {drv_a, drv_b}, 1);
    chk(valid == 2'b11, "R8 valid kept", valid, 3);
    oe_off = 2'b10;
    @(negedge clk);
    chk(drv_a && !drv_b, "R8 disable B", {drv_a, drv_b}, 2);
    oe_off = 2'b00;
    @(negedge clk);

    // R9 nap on A, R11 independence, R13 hold
    held = bus_a;
    shdn = 2'b01;
    @(negedge clk);
    chk(!drv_a && valid[0] == 0, "R9 nap quiet", {drv_a, valid[0]}, 0);
    smp_a = W'(33); smp_b = W'(17); ovr_a = 1;
    repeat (3) @(negedge clk);
    chk(bus_a == held && !of_a, "R13 hold in nap", bus_a, held);
    chk(valid[1] && drv_b && bus_b == W'(17), "R11 B runs", bus_b, 17);
    ovr_a = 0;
    shdn = 2'b00;
    for (int i = 1; i <= NAP; i++) begin
      @(negedge clk);
      chk(valid[0] == 0, "R9 nap recovery low", valid[0], 0);
      chk(valid[1] == 1, "R11 B valid", valid[1], 1);
    end
    @(negedge clk);
    chk(valid[0] == 1, "R9 nap recovery done", valid[0], 1);
    chk(bus_a == W'(33), "R9 data after nap", bus_a, 33);

    // R10 sleep on B
    shdn = 2'b10; oe_off = 2'b10;
    repeat (2) @(negedge clk);
    chk(!drv_b && valid[1] == 0, "R10 sleep quiet", {drv_b, valid[1]}, 0);
    chk(drv_a && valid[0], "R11 A runs", {drv_a, valid[0]}, 3);
    shdn = 2'b00; oe_off = 2'b00;
    for (int i = 1; i <= SLEEP; i++) begin
      @(negedge clk);
      chk(valid[1] == 0, "R10 sleep recovery low", valid[1], 0);
    end
    @(negedge clk);
    chk(valid[1] == 1, "R10 sleep recovery done", valid[1], 1);
    chk(drv_b, "R8 drive after sleep", drv_b, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule